// File: doc/BRIEF.md
# Processor Run-State Controller

This block keeps track of the top-level run state of a processor core. The four states are normal execution, stopped, exception processing and debug. A stop instruction moves the core from normal into the stopped state. While the core is stopped, the block watches several wake sources and decides where execution goes next:

- back to normal, resuming at the instruction after the stop;
- into exception processing, to service an interrupt or a debug exception;
- straight into debug.

Each wake source is a plain level input, sampled on the rising clock edge. There is no data stream and no handshake. The exception logic reads the current state from `state_o`. It also reads `dbg_exc_o`, which tells it that the exception it is servicing is a debug exception and not an external interrupt. A separate one-cycle pulse, `resume_next_o`, tells the fetch logic to continue at the instruction after the stop. All outputs are registered. A decision made on a clock edge is visible on the outputs right after that edge.

Top module: `run_state_ctrl`

## Requirements
- R1: A synchronous active-high `rst` sampled on a rising edge sets the state to normal, from any state, and clears `resume_next_o` and `dbg_exc_o`.
- R2: `state_o` encodes normal as 0, stopped as 1, exception as 2 and debug as 3. In normal state, `stop_req_i` high on a rising edge makes the state stopped after that edge. In any other state, `stop_req_i` has no effect.
- R3: While stopped, with `wake_i`, `irq_pend_i`, `dbg_pin_i` and `tap_dbg_req_i` all low, the state stays stopped.
- R4: While stopped, `wake_i` high with `irq_pend_i` low and no debug request makes the state normal after the edge. `resume_next_o` is high for exactly that one cycle.
- R5: While stopped, `irq_pend_i` high with no debug request makes the state exception after the edge, with or without `wake_i`. In this case `dbg_exc_o` stays low and `resume_next_o` does not pulse.
- R6: While stopped, `dbg_pin_i` or `tap_dbg_req_i` high with `irq_mode_en_i` low makes the state debug after the edge, with `dbg_exc_o` low.
- R7: While stopped, `dbg_pin_i` or `tap_dbg_req_i` high with `irq_mode_en_i` high makes the state exception after the edge. `dbg_exc_o` is then high for the whole stay in exception, and `dbg_exc_o` is never high outside exception state.
- R8: A debug request in the same cycle as `irq_pend_i` is handled as in R6 or R7. The interrupt is not selected.
- R9: In exception state, `svc_done_i` returns the state to normal after the edge, and `dbg_exit_i` is ignored. In debug state, `dbg_exit_i` returns the state to normal, and `svc_done_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stop_req_i | input | 1 | Stop instruction executed |
| wake_i | input | 1 | Non-interrupt exit event from stop |
| irq_pend_i | input | 1 | An external interrupt is pending and serviceable |
| dbg_pin_i | input | 1 | External debug request pin |
| tap_dbg_req_i | input | 1 | Debug request from the test port |
| irq_mode_en_i | input | 1 | 1: a debug wake becomes a debug exception |
| svc_done_i | input | 1 | One-cycle pulse: exception service finished |
| dbg_exit_i | input | 1 | Leave debug state |
| state_o | output | 2 | Current state: 0 normal, 1 stop, 2 exception, 3 debug |
| resume_next_o | output | 1 | One-cycle pulse: resume after the stop instruction |
| dbg_exc_o | output | 1 | The current exception is a debug exception |

## Verification
A debug wake-up and an interrupt wake-up can arrive in the same stopped cycle. Their outcomes differ, and a fixed priority has to choose between them. The bench drives `irq_pend_i` together with the debug pin or the test-port request on the same edge, once with the mode bit clear and once with it set. A correct result is debug state in the first case, and exception state with the debug-exception flag high in the second. The exit inputs of the state the block is not in (`svc_done_i` in debug, `dbg_exit_i` in exception) are also driven, to show they have no effect.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    RS_NORMAL = 2'd0,
    RS_STOP   = 2'd1,
    RS_EXCEPT = 2'd2,
    RS_DEBUG  = 2'd3
  } run_state_t;

  // Outcome of one stopped cycle; at most one bit set.
  typedef struct packed {
    logic go_debug;
    logic go_dbg_exc;
    logic go_irq_exc;
    logic go_resume;
  } wake_cause_t;

endpackage

// File: rtl/rsc_wake_arbiter.sv
module rsc_wake_arbiter
  import rsc_pkg::*;
(
  input  logic        wake_i,
  input  logic        irq_pend_i,
  input  logic        dbg_pin_i,
  input  logic        tap_dbg_req_i,
  input  logic        irq_mode_en_i,
  output wake_cause_t cause_o
);

  logic dbg_any;

  assign dbg_any = dbg_pin_i | tap_dbg_req_i;

  // Fixed priority: debug request, then interrupt, then plain wake.
  always_comb begin
    cause_o = '0;
    if (dbg_any) begin
      if (irq_mode_en_i) cause_o.go_dbg_exc = 1'b1;
      else               cause_o.go_debug   = 1'b1;
    end else if (irq_pend_i) begin
      cause_o.go_irq_exc = 1'b1;
    end else if (wake_i) begin
      cause_o.go_resume = 1'b1;
    end
  end

endmodule

// File: rtl/rsc_state_core.sv
module rsc_state_core
  import rsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        stop_req_i,
  input  logic        svc_done_i,
  input  logic        dbg_exit_i,
  input  wake_cause_t cause_i,
  output run_state_t  state_o,
  output logic        resume_o,
  output logic        dbg_exc_o
);

  run_state_t state_q, state_d;
  logic       resume_d, dbg_exc_d;

  always_comb begin
    state_d   = state_q;
    resume_d  = 1'b0;
    dbg_exc_d = dbg_exc_o;
    unique case (state_q)
      RS_NORMAL: begin
        dbg_exc_d = 1'b0;
        if (stop_req_i) state_d = RS_STOP;
      end
      RS_STOP: begin
        dbg_exc_d = 1'b0;
        if (cause_i.go_debug) begin
          state_d = RS_DEBUG;
        end else if (cause_i.go_dbg_exc) begin
          state_d   = RS_EXCEPT;
          dbg_exc_d = 1'b1;
        end else if (cause_i.go_irq_exc) begin
          state_d = RS_EXCEPT;
        end else if (cause_i.go_resume) begin
          state_d  = RS_NORMAL;
          resume_d = 1'b1;
        end
      end
      RS_EXCEPT: begin
        if (svc_done_i) begin
          state_d   = RS_NORMAL;
          dbg_exc_d = 1'b0;
        end
      end
      RS_DEBUG: begin
        dbg_exc_d = 1'b0;
        if (dbg_exit_i) state_d = RS_NORMAL;
      end
      default: begin
        state_d   = RS_NORMAL;
        dbg_exc_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= RS_NORMAL;
      resume_o  <= 1'b0;
      dbg_exc_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      resume_o  <= resume_d;
      dbg_exc_o <= dbg_exc_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/run_state_ctrl.sv
module run_state_ctrl
  import rsc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               stop_req_i,
  input  logic               wake_i,
  input  logic               irq_pend_i,
  input  logic               dbg_pin_i,
  input  logic               tap_dbg_req_i,
  input  logic               irq_mode_en_i,
  input  logic               svc_done_i,
  input  logic               dbg_exit_i,
  output logic [STATE_W-1:0] state_o,
  output logic               resume_next_o,
  output logic               dbg_exc_o
);

  wake_cause_t cause;
  run_state_t  state;

  rsc_wake_arbiter u_arb (
    .wake_i        (wake_i),
    .irq_pend_i    (irq_pend_i),
    .dbg_pin_i     (dbg_pin_i),
    .tap_dbg_req_i (tap_dbg_req_i),
    .irq_mode_en_i (irq_mode_en_i),
    .cause_o       (cause)
  );

  rsc_state_core u_core (
    .clk        (clk),
    .rst        (rst),
    .stop_req_i (stop_req_i),
    .svc_done_i (svc_done_i),
    .dbg_exit_i (dbg_exit_i),
    .cause_i    (cause),
    .state_o    (state),
    .resume_o   (resume_next_o),
    .dbg_exc_o  (dbg_exc_o)
  );

  assign state_o = state;

endmodule

// File: rtl/run_state_ctrl_chk.sv
module run_state_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       stop_req_i,
  input logic       wake_i,
  input logic       irq_pend_i,
  input logic       dbg_pin_i,
  input logic       tap_dbg_req_i,
  input logic       irq_mode_en_i,
  input logic       svc_done_i,
  input logic       dbg_exit_i,
  input logic [1:0] state_o,
  input logic       resume_next_o,
  input logic       dbg_exc_o
);

  logic dbg_w;
  assign dbg_w = dbg_pin_i | tap_dbg_req_i;

  // R1
  reset_to_normal_chk: assert property (@(posedge clk)
    rst |=> (state_o == 2'd0 && !resume_next_o && !dbg_exc_o));

  // R2
  stop_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0 && stop_req_i) |=> state_o == 2'd1);

  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1 && !wake_i && !irq_pend_i && !dbg_w) |=> state_o == 2'd1);

  // R4
  resume_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1 && wake_i && !irq_pend_i && !dbg_w) |=> (resume_next_o && state_o == 2'd0));

  // R4
  resume_only_normal_chk: assert property (@(posedge clk) disable iff (rst)
    resume_next_o |-> state_o == 2'd0);

  // R5
  irq_exc_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1 && irq_pend_i && !dbg_w) |=> (state_o == 2'd2 && !dbg_exc_o));

  // R6
  dbg_direct_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1 && dbg_w && !irq_mode_en_i) |=> state_o == 2'd3);

  // R7
  dbg_exc_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1 && dbg_w && irq_mode_en_i) |=> (state_o == 2'd2 && dbg_exc_o));

  // R7
  dbg_exc_scope_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_exc_o |-> state_o == 2'd2);

  // R9
  svc_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2 && svc_done_i) |=> state_o == 2'd0);

  // R9
  dbg_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd3 && dbg_exit_i) |=> state_o == 2'd0);

endmodule

bind run_state_ctrl run_state_ctrl_chk u_chk (.*);

// File: tb/run_state_ctrl_tb.sv
`timescale 1ns/1ps
module run_state_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stop_req_i = 0, wake_i = 0, irq_pend_i = 0, dbg_pin_i = 0;
  logic       tap_dbg_req_i = 0, irq_mode_en_i = 0, svc_done_i = 0, dbg_exit_i = 0;
  logic [1:0] state_o;
  logic       resume_next_o, dbg_exc_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [1:0] S_NRM = 2'd0, S_STP = 2'd1, S_EXC = 2'd2, S_DBG = 2'd3;

  always #4 clk = ~clk;

  run_state_ctrl u_dut (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    stop_req_i = 0; wake_i = 0; irq_pend_i = 0; dbg_pin_i = 0;
    tap_dbg_req_i = 0; irq_mode_en_i = 0; svc_done_i = 0; dbg_exit_i = 0;
  endtask

  task automatic enter_stop(string req);
    stop_req_i = 1; step(); stop_req_i = 0;
    chk(req, "state after stop request", state_o, S_STP);
  endtask

  task automatic t_reset();
    rst = 1; step(); step(); rst = 0;
    chk("R1", "state at reset", state_o, S_NRM);
    chk("R1", "resume at reset", resume_next_o, 0);
    chk("R1", "dbg_exc at reset", dbg_exc_o, 0);
  endtask

  task automatic t_stop_hold();
    enter_stop("R2");
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R3", "stop held without wake", state_o, S_STP);
    end
  endtask

  task automatic t_plain_wake();
    wake_i = 1; step(); wake_i = 0;
    chk("R4", "state after plain wake", state_o, S_NRM);
    chk("R4", "resume pulse", resume_next_o, 1);
    step();
    chk("R4", "resume pulse width", resume_next_o, 0);
  endtask

  task automatic t_irq_wake(bit with_wake);
    enter_stop("R2");
    irq_pend_i = 1; wake_i = with_wake; step(); irq_pend_i = 0; wake_i = 0;
    chk("R5", "state after irq wake", state_o, S_EXC);
    chk("R5", "dbg_exc for irq", dbg_exc_o, 0);
    chk("R5", "no resume for irq", resume_next_o, 0);
    dbg_exit_i = 1; stop_req_i = 1; step(); dbg_exit_i = 0; stop_req_i = 0;
    chk("R9", "dbg_exit ignored in exception", state_o, S_EXC);
    svc_done_i = 1; step(); svc_done_i = 0;
    chk("R9", "exception exit on svc_done", state_o, S_NRM);
  endtask

  task automatic t_dbg_direct(bit use_tap);
    enter_stop("R2");
    irq_mode_en_i = 0;
    if (use_tap) tap_dbg_req_i = 1; else dbg_pin_i = 1;
    step(); tap_dbg_req_i = 0; dbg_pin_i = 0;
    chk("R6", use_tap ? "debug via test port" : "debug via pin", state_o, S_DBG);
    chk("R6", "dbg_exc in debug", dbg_exc_o, 0);
    svc_done_i = 1; stop_req_i = 1; step(); svc_done_i = 0; stop_req_i = 0;
    chk("R9", "svc_done ignored in debug", state_o, S_DBG);
    chk("R2", "stop_req ignored in debug", state_o, S_DBG);
    dbg_exit_i = 1; step(); dbg_exit_i = 0;
    chk("R9", "debug exit", state_o, S_NRM);
  endtask

  task automatic t_dbg_exc();
    enter_stop("R2");
    irq_mode_en_i = 1; dbg_pin_i = 1; step(); dbg_pin_i = 0; irq_mode_en_i = 0;
    chk("R7", "state for debug exception", state_o, S_EXC);
    chk("R7", "dbg_exc raised", dbg_exc_o, 1);
    step(); step();
    chk("R7", "dbg_exc held", dbg_exc_o, 1);
    svc_done_i = 1; step(); svc_done_i = 0;
    chk("R9", "exit debug exception", state_o, S_NRM);
    chk("R7", "dbg_exc cleared in normal", dbg_exc_o, 0);
  endtask

  task automatic t_collide();
    enter_stop("R2");
    irq_pend_i = 1; tap_dbg_req_i = 1; irq_mode_en_i = 0; step();
    idle_inputs();
    chk("R8", "debug beats irq (mode clear)", state_o, S_DBG);
    dbg_exit_i = 1; step(); dbg_exit_i = 0;
    enter_stop("R2");
    irq_pend_i = 1; dbg_pin_i = 1; irq_mode_en_i = 1; step();
    idle_inputs();
    chk("R8", "debug beats irq (mode set) state", state_o, S_EXC);
    chk("R8", "debug beats irq (mode set) flag", dbg_exc_o, 1);
    svc_done_i = 1; step(); svc_done_i = 0;
  endtask

  task automatic t_mid_reset();
    enter_stop("R2");
    dbg_pin_i = 1; irq_mode_en_i = 1; step(); idle_inputs();
    rst = 1; step(); rst = 0;
    chk("R1", "reset from exception", state_o, S_NRM);
    chk("R1", "reset clears dbg_exc", dbg_exc_o, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_stop_hold();
    t_plain_wake();
    t_irq_wake(1'b0);
    t_irq_wake(1'b1);
    t_dbg_direct(1'b0);
    t_dbg_direct(1'b1);
    t_dbg_exc();
    t_collide();
    t_mid_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int n = 0; n < 5000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule